// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit decides the program-counter step for one sequencer instruction. It covers three kinds of instruction:

- **Plain instructions.** The counter moves on by one word.
- **Conditional relative branches.** The unit tests the status byte, either one chosen flag or the signed relation formed by exclusive-OR of the negative and overflow flags. On a taken branch it adds a 7-bit signed displacement plus one.
- **Skips.** A skip fires on a register-equality result or on a sampled register or I/O bit being clear or set. It then steps over the following instruction, whose length of one or two words is supplied by the fetch side.

Each accepted request gives one registered result one clock later. The result holds the next program counter and the number of cycles the instruction takes. Fetch, the call/return stack and indirect jumps sit outside this block. The output registers use an asynchronous active-low reset whose release is synchronised inside the block.

Top module: `branch_skip_unit`

## Requirements
- R1: While reset is active, and until the first accepted request, res_valid, res_pc and res_cycles are all 0.
- R2: An op code of 0 (plain) or 3 (reserved) gives res_pc = in_pc + 1 and res_cycles = 1.
- R3: A taken branch (op code 1) gives res_pc = in_pc + sign-extended br_offset + 1, modulo 2^PC_W, and res_cycles = 2. This includes wrap past the top and below zero.
- R4: A branch that is not taken gives res_pc = in_pc + 1 and res_cycles = 1.
- R5: With br_signed = 0, the tested value is in_status[br_bit_sel]. The bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, and every position can be selected. The branch is taken when the tested value equals br_on_set.
- R6: With br_signed = 1, the tested value is in_status[2] XOR in_status[3]. The stored S bit (bit 4) and br_bit_sel have no effect. The branch is taken when the tested value equals br_on_set, so br_on_set = 0 gives greater-or-equal and br_on_set = 1 gives less-than.
- R7: A skip (op code 2) that fires gives res_pc = in_pc + 2 and res_cycles = 2 when skip_over_long = 0. It gives in_pc + 3 and 3 cycles when skip_over_long = 1.
- R8: skip_kind selects the skip test:
  - 0 fires when skip_regs_equal = 1.
  - 1 fires when skip_test_bit = 0.
  - 2 fires when skip_test_bit = 1.
- R9: A skip that does not fire, and any skip with skip_kind = 3, gives res_pc = in_pc + 1 and res_cycles = 1, whatever the value of skip_over_long.
- R10: The result of a request accepted at one rising edge is visible from the following edge, with res_valid = 1. A cycle with in_valid = 0 gives res_valid = 0 and leaves res_pc and res_cycles unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 plain, 1 branch, 2 skip, 3 reserved |
| in_pc | input | PC_W | Current program counter (word address) |
| in_status | input | 8 | Status byte (C0 Z1 N2 V3 S4 H5 T6 I7) |
| br_signed | input | 1 | Branch tests N XOR V instead of one flag |
| br_bit_sel | input | 3 | Flag position tested when br_signed = 0 |
| br_on_set | input | 1 | Branch taken when the tested value is 1 (else when 0) |
| br_offset | input | K_W | Two's-complement branch displacement |
| skip_kind | input | 2 | 0 equality, 1 bit clear, 2 bit set, 3 never |
| skip_regs_equal | input | 1 | Register comparison result |
| skip_test_bit | input | 1 | Selected register or I/O bit value |
| skip_over_long | input | 1 | Following instruction is two words long |
| res_valid | output | 1 | Result valid |
| res_pc | output | PC_W | Next program counter |
| res_cycles | output | 2 | Cycles the instruction takes (1 to 3) |

## Verification
Every result is due exactly one rising edge after the request that caused it, because only one register stage sits between the request inputs and the result outputs. The bench applies each request on a falling edge and reads the result on the next falling edge, so it samples half a cycle after the capturing edge. Idle cycles are checked on that same falling edge: res_valid must be low and the previous counter and cycle count must still be present. After reset is released, the bench waits out the two-stage synchroniser before it issues the first request.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_BRANCH = 2'd1,
    OP_SKIP   = 2'd2,
    OP_RSVD   = 2'd3
  } bsu_op_e;

  typedef enum logic [1:0] {
    SK_EQUAL  = 2'd0,
    SK_BITCLR = 2'd1,
    SK_BITSET = 2'd2,
    SK_NEVER  = 2'd3
  } bsu_skip_e;

  localparam int STAT_W  = 8;
  localparam int SEL_W   = $clog2(STAT_W);
  localparam int FLAG_N  = 2;
  localparam int FLAG_V  = 3;
  localparam int CYC_W   = 2;

endpackage

// File: rtl/bsu_rst_sync.sv
module bsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bsu_branch_cond.sv
module bsu_branch_cond
  import bsu_pkg::*;
(
  input  logic [STAT_W-1:0] status,
  input  logic              signed_mode,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              on_set,
  output logic              taken
);

  logic [STAT_W-1:0] sel_hit;
  logic              flag_val;
  logic              signed_val;
  logic              tested;

  // one-hot pick of the selected flag
  for (genvar g = 0; g < STAT_W; g++) begin : g_pick
    assign sel_hit[g] = (bit_sel == SEL_W'(g)) & status[g];
  end

  always_comb begin
    flag_val   = |sel_hit;
    signed_val = status[FLAG_N] ^ status[FLAG_V];
    tested     = signed_mode ? signed_val : flag_val;
    taken      = (tested == on_set);
  end

endmodule

// File: rtl/bsu_skip_cond.sv
module bsu_skip_cond
  import bsu_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       regs_equal,
  input  logic       test_bit,
  output logic       fire
);

  bsu_skip_e kind_e;

  always_comb begin
    kind_e = bsu_skip_e'(kind);
    unique case (kind_e)
      SK_EQUAL:  fire = regs_equal;
      SK_BITCLR: fire = ~test_bit;
      SK_BITSET: fire = test_bit;
      default:   fire = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsu_next_pc.sv
module bsu_next_pc
  import bsu_pkg::*;
#(
  parameter int PC_W = 9,
  parameter int K_W  = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [K_W-1:0]   offset,
  input  logic [1:0]       op,
  input  logic             br_taken,
  input  logic             skip_fire,
  input  logic             skip_long,
  output logic [PC_W-1:0]  next_pc,
  output logic [CYC_W-1:0] cycles
);

  logic [PC_W-1:0] off_ext;
  bsu_op_e         op_e;
  logic            take_rel;

  // sign extension, or truncation when the counter is narrower
  if (PC_W > K_W) begin : g_ext
    assign off_ext = {{(PC_W-K_W){offset[K_W-1]}}, offset};
  end else begin : g_trunc
    assign off_ext = offset[PC_W-1:0];
  end

  always_comb begin
    op_e     = bsu_op_e'(op);
    take_rel = 1'b0;
    cycles   = CYC_W'(1);
    unique case (op_e)
      OP_BRANCH: begin
        take_rel = br_taken;
        cycles   = br_taken ? CYC_W'(2) : CYC_W'(1);
      end
      OP_SKIP: begin
        if (skip_fire) cycles = skip_long ? CYC_W'(3) : CYC_W'(2);
      end
      default: cycles = CYC_W'(1);
    endcase
    // a skip advances by its own cycle count; plain steps by one
    if (take_rel) next_pc = pc + off_ext + PC_W'(1);
    else          next_pc = pc + PC_W'(cycles);
  end

endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int PC_W = 9,
  parameter int K_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [7:0]       in_status,
  input  logic             br_signed,
  input  logic [2:0]       br_bit_sel,
  input  logic             br_on_set,
  input  logic [K_W-1:0]   br_offset,
  input  logic [1:0]       skip_kind,
  input  logic             skip_regs_equal,
  input  logic             skip_test_bit,
  input  logic             skip_over_long,
  output logic             res_valid,
  output logic [PC_W-1:0]  res_pc,
  output logic [1:0]       res_cycles
);

  logic             rst_sync_n;
  logic             br_taken;
  logic             skip_fire;
  logic [PC_W-1:0]  pc_calc;
  logic [CYC_W-1:0] cyc_calc;

  logic             valid_q, valid_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;

  bsu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bsu_branch_cond u_cond (
    .status      (in_status),
    .signed_mode (br_signed),
    .bit_sel     (br_bit_sel),
    .on_set      (br_on_set),
    .taken       (br_taken)
  );

  bsu_skip_cond u_skip (
    .kind       (skip_kind),
    .regs_equal (skip_regs_equal),
    .test_bit   (skip_test_bit),
    .fire       (skip_fire)
  );

  bsu_next_pc #(.PC_W(PC_W), .K_W(K_W)) u_npc (
    .pc        (in_pc),
    .offset    (br_offset),
    .op        (in_op),
    .br_taken  (br_taken),
    .skip_fire (skip_fire),
    .skip_long (skip_over_long),
    .next_pc   (pc_calc),
    .cycles    (cyc_calc)
  );

  always_comb begin
    valid_d = in_valid;
    pc_d    = pc_calc;
    cyc_d   = cyc_calc;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      cyc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        pc_q  <= pc_d;
        cyc_q <= cyc_d;
      end
    end
  end

  assign res_valid  = valid_q;
  assign res_pc     = pc_q;
  assign res_cycles = cyc_q;

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int PC_W = 9,
  parameter int K_W  = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_op,
  input logic [PC_W-1:0] in_pc,
  input logic [K_W-1:0]  br_offset,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic [1:0]      res_cycles
);

  logic [PC_W-1:0] off_sx;
  assign off_sx = PC_W'($signed(br_offset));

  // R10
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_pc) && $stable(res_cycles)));

  // R2
  single_cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 2'd1) |=>
      (res_cycles != 2'd1 || res_pc == PC_W'($past(in_pc) + PC_W'(1))));

  // R7
  skip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd2) |=>
      (res_cycles != 2'd0 && res_pc == PC_W'($past(in_pc) + PC_W'(res_cycles))));

  // R3
  branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'd1) |=>
      (res_cycles == 2'd1 ||
       (res_cycles == 2'd2 && res_pc == PC_W'($past(in_pc) + $past(off_sx) + PC_W'(1)))));

endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W), .K_W(K_W)) u_bsu_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_pc      (in_pc),
  .br_offset  (br_offset),
  .res_valid  (res_valid),
  .res_pc     (res_pc),
  .res_cycles (res_cycles)
);

// File: tb/branch_skip_unit_test.sv
module branch_skip_unit_test;

  localparam int PC_W = 9;
  localparam int K_W  = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      in_op = '0;
  logic [PC_W-1:0] in_pc = '0;
  logic [7:0]      in_status = '0;
  logic            br_signed = 1'b0;
  logic [2:0]      br_bit_sel = '0;
  logic            br_on_set = 1'b0;
  logic [K_W-1:0]  br_offset = '0;
  logic [1:0]      skip_kind = '0;
  logic            skip_regs_equal = 1'b0;
  logic            skip_test_bit = 1'b0;
  logic            skip_over_long = 1'b0;
  logic            res_valid;
  logic [PC_W-1:0] res_pc;
  logic [1:0]      res_cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W), .K_W(K_W)) uut (.*);

  function automatic logic [PC_W+1:0] model(
      input logic [1:0] op, input logic [PC_W-1:0] pc, input logic [7:0] st,
      input logic sgn, input logic [2:0] sel, input logic on_set,
      input logic [K_W-1:0] k, input logic [1:0] sk, input logic eq,
      input logic tb, input logic lng);
    logic val, tk, fire;
    int   kv;
    logic [PC_W-1:0] np;
    logic [1:0] cy;
    np = PC_W'(pc + 1);
    cy = 2'd1;
    if (op == 2'd1) begin
      val = sgn ? (st[2] ^ st[3]) : st[sel];
      tk  = (val == on_set);
      kv  = k[K_W-1] ? int'(k) - (1 << K_W) : int'(k);
      if (tk) begin np = PC_W'(int'(pc) + kv + 1); cy = 2'd2; end
    end else if (op == 2'd2) begin
      fire = (sk == 2'd0) ? eq : (sk == 2'd1) ? !tb : (sk == 2'd2) ? tb : 1'b0;
      if (fire) begin
        cy = lng ? 2'd3 : 2'd2;
        np = PC_W'(pc + cy);
      end
    end
    return {np, cy};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [1:0] op, input logic [PC_W-1:0] pc,
      input logic [7:0] st, input logic sgn, input logic [2:0] sel, input logic on_set,
      input logic [K_W-1:0] k, input logic [1:0] sk, input logic eq, input logic tb,
      input logic lng);
    logic [PC_W+1:0] e;
    in_valid = 1'b1; in_op = op; in_pc = pc; in_status = st; br_signed = sgn;
    br_bit_sel = sel; br_on_set = on_set; br_offset = k; skip_kind = sk;
    skip_regs_equal = eq; skip_test_bit = tb; skip_over_long = lng;
    e = model(op, pc, st, sgn, sel, on_set, k, sk, eq, tb, lng);
    @(negedge clk);
    check({tag, " valid"}, 32'(res_valid), 32'd1);
    check({tag, " pc"}, 32'(res_pc), 32'(e[PC_W+1:2]));
    check({tag, " cycles"}, 32'(res_cycles), 32'(e[1:0]));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B15));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 pc", 32'(res_pc), 32'd0);
    check("R1 cycles", 32'(res_cycles), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'({res_valid, res_pc, res_cycles}), 32'd0);

    // R2 plain and reserved ops
    issue("R2 plain", 2'd0, 9'h010, 8'h00, 0, 0, 0, 7'h00, 0, 0, 0, 1);
    issue("R2 reserved", 2'd3, 9'h1FF, 8'hFF, 0, 0, 1, 7'h05, 0, 1, 1, 1);
    // R3 wrap forward and backward
    issue("R3 wrap up", 2'd1, 9'h1FE, 8'h01, 0, 3'd0, 1, 7'h3F, 0, 0, 0, 0);
    issue("R3 wrap down", 2'd1, 9'h002, 8'h02, 0, 3'd1, 1, 7'h40, 0, 0, 0, 0);
    // R4 not taken
    issue("R4 not taken", 2'd1, 9'h080, 8'h00, 0, 3'd7, 1, 7'h10, 0, 0, 0, 0);
    // R5 each flag position, set and clear polarity
    for (int b = 0; b < 8; b++) begin
      issue("R5 flag set", 2'd1, 9'h100, 8'(1 << b), 0, 3'(b), 1, 7'h08, 0, 0, 0, 0);
      issue("R5 flag clear", 2'd1, 9'h100, 8'(1 << b), 0, 3'(b), 0, 7'h08, 0, 0, 0, 0);
    end
    // R6 signed: S bit disagrees with N^V and must not matter
    issue("R6 ge with S set", 2'd1, 9'h040, 8'h1C, 1, 3'd4, 0, 7'h7E, 0, 0, 0, 0);
    issue("R6 lt with S clear", 2'd1, 9'h040, 8'h04, 1, 3'd4, 1, 7'h7E, 0, 0, 0, 0);
    issue("R6 lt not taken", 2'd1, 9'h040, 8'h10, 1, 3'd2, 1, 7'h7E, 0, 0, 0, 0);
    // R7 equality skip, one and two words
    issue("R7 skip short", 2'd2, 9'h1FE, 8'h00, 0, 0, 0, 0, 2'd0, 1, 0, 0);
    issue("R7 skip long", 2'd2, 9'h1FE, 8'h00, 0, 0, 0, 0, 2'd0, 1, 0, 1);
    // R8 bit clear / set tests
    issue("R8 bit clear fires", 2'd2, 9'h020, 8'h00, 0, 0, 0, 0, 2'd1, 0, 0, 1);
    issue("R8 bit set fires", 2'd2, 9'h020, 8'h00, 0, 0, 0, 0, 2'd2, 0, 1, 0);
    // R9 no skip, long flag ignored; reserved kind never fires
    issue("R9 eq false", 2'd2, 9'h030, 8'h00, 0, 0, 0, 0, 2'd0, 0, 1, 1);
    issue("R9 bit set false", 2'd2, 9'h030, 8'h00, 0, 0, 0, 0, 2'd2, 1, 0, 1);
    issue("R9 reserved kind", 2'd2, 9'h030, 8'h00, 0, 0, 0, 0, 2'd3, 1, 1, 1);
    // R10 idle cycle holds result
    begin
      logic [PC_W-1:0] hp;
      logic [1:0] hc;
      hp = res_pc; hc = res_cycles;
      in_valid = 1'b0; in_pc = 9'h155; in_op = 2'd1;
      @(negedge clk);
      check("R10 idle valid", 32'(res_valid), 32'd0);
      check("R10 idle pc hold", 32'(res_pc), 32'(hp));
      check("R10 idle cycles hold", 32'(res_cycles), 32'(hc));
    end
    // random mix covering R2..R9
    for (int i = 0; i < 600; i++) begin
      issue("R3 R5 R7 random", 2'($urandom), 9'($urandom), 8'($urandom), 1'($urandom),
            3'($urandom), 1'($urandom), 7'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
      if ((i % 37) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 random idle", 32'(res_valid), 32'd0);
      end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule